// File: doc/BRIEF.md
# RMII to MII Receive Adapter

This block sits between an external reduced-pin Ethernet PHY and a MAC whose receive side expects a 4-bit media-independent interface. Everything runs on the single 50 MHz reference clock. The PHY side supplies a 2-bit receive bus and one combined carrier-sense/data-valid line. The MAC side gets a rebuilt 4-bit nibble, a receive data-valid flag and a receive clock. That clock is derived from the reference: 25 MHz at 100 Mbps and 2.5 MHz at 10 Mbps.

At 10 Mbps the PHY repeats every dibit for ten reference cycles. A decimator keeps exactly one of those ten samples, placed mid-period from the first detected edge. An assembler pairs the kept dibits into nibbles. It locks nibble alignment to the first non-zero preamble dibit and closes a frame once the carrier line has been seen low twice in a row. An output stage hands each complete nibble to the MAC side on a rising edge of the rebuilt receive clock. The speed input is expected to change only while reset is asserted.

Top module: `rmii_rx_adapter`

## Requirements
- R1: With `speed_100` = 1, the dibit present in every reference cycle is used, and consecutive dibits are paired into nibbles.
- R2: With `speed_100` = 0, each dibit held for ten reference cycles yields one sample. The sample is taken from the fifth cycle (index 4) of the period, counted from the input change that aligned the phase. Values on the other cycles of a period have no effect on the output nibbles.
- R3: The earlier dibit of a pair becomes `mii_rxd[1:0]` and the later one becomes `mii_rxd[3:2]`.
- R4: A frame starts at the first sampled dibit that is non-zero (01, 10 or 11) while `rmii_crs_dv` is high. Zero dibits sampled before it are discarded, so a burst of only zero dibits produces no valid nibble.
- R5: A frame ends when `rmii_crs_dv` is sampled low on two consecutive dibit samples, and any half-built nibble is then dropped. A single low sample between high ones (carrier toggling) does not end the frame, and its dibit is kept as data.
- R6: `mii_rx_clk` has a period of 2 reference cycles at 100 Mbps and 20 at 10 Mbps, with equal high and low times.
- R7: `mii_rxd` and `mii_rx_dv` change only at the reference edge on which `mii_rx_clk` rises.
- R8: While `rst_n` is low, `mii_rxd`, `mii_rx_dv` and `mii_rx_clk` are all 0.
- R9: Every nibble of a frame is presented with `mii_rx_dv` = 1 for exactly one `mii_rx_clk` period, in arrival order, with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| speed_100 | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps; static outside reset |
| rmii_rxd | input | 2 | Receive dibit from the PHY |
| rmii_crs_dv | input | 1 | Combined carrier sense / data valid from the PHY |
| mii_rx_clk | output | 1 | Rebuilt receive clock, 25 MHz or 2.5 MHz |
| mii_rxd | output | 4 | Rebuilt receive nibble |
| mii_rx_dv | output | 1 | Receive data valid for `mii_rxd` |

## Verification
The bench sweeps both speeds with zero, one, two and three leading zero dibits. An odd count catches an assembler that aligns on carrier rise instead of on the first non-zero dibit, because every later nibble would then come out with its halves crossed. At 10 Mbps the bench inverts the data on cycles 1, 2, 7 and 8 of each held dibit. A decimator sampling off-centre, or re-phasing on every edge, would return corrupted nibbles. Frame tails toggle the carrier line low for single samples, and a pure-zero burst is sent with carrier high. These catch a design that ends a frame on one low sample (too few nibbles) or starts a frame on zeros (spurious valid data). The spacing between clock rises and the stability of the outputs between rises are also watched, which exposes a wrong divider or an output that bypasses the hand-over register.

// File: rtl/rmii_rx_pkg.sv
// Shared types for the reduced-pin to nibble receive adapter.
// Assumes: dibit and nibble widths are fixed by the two interfaces.
package rmii_rx_pkg;

    typedef logic [1:0] dibit_t;
    typedef logic [3:0] nibble_t;

    // One decimated receive sample handed from the decimator to the assembler.
    typedef struct packed {
        logic   vld;
        logic   crs;
        dibit_t d;
    } dibit_smp_t;

endpackage

// File: rtl/rmii_rx_decim.sv
// Decimator: registers the PHY inputs and emits one sample per dibit period.
// At 100 Mbps every reference cycle is a sample. At 10 Mbps a phase counter
// picks cycle SAMPLE_IDX of each OVERSAMPLE-cycle period. The phase re-aligns
// to the first input change seen while unlocked. It locks there and unlocks
// again once a sample shows carrier low.
// Assumes: speed_100 only changes while rst_n is low.
module rmii_rx_decim
    import rmii_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 10,
    parameter int SAMPLE_IDX = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       speed_100,
    input  dibit_t     rxd_in,
    input  logic       crs_in,
    output dibit_smp_t smp_o
);

    localparam int PW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [PW-1:0] PH_LAST = PW'(OVERSAMPLE - 1);
    localparam logic [PW-1:0] PH_SMP  = PW'(SAMPLE_IDX);

    dibit_t        rxd_q;
    logic          crs_q;
    logic [PW-1:0] phase_q;
    logic          locked_q;
    dibit_smp_t    smp_q;
    logic          chg;
    logic          take;

    // Detect an input edge against the registered copy.
    always_comb chg = ({rxd_in, crs_in} != {rxd_q, crs_q});

    // Decide whether this cycle's registered dibit is the one to keep.
    always_comb take = speed_100 ? 1'b1 : (phase_q == PH_SMP);

    // Input register, phase tracking and sample capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxd_q    <= '0;
            crs_q    <= 1'b0;
            phase_q  <= '0;
            locked_q <= 1'b0;
            smp_q    <= '0;
        end else begin
            rxd_q <= rxd_in;
            crs_q <= crs_in;
            if (!locked_q && chg) begin
                phase_q  <= '0;
                locked_q <= 1'b1;
            end else if (phase_q == PH_LAST) begin
                phase_q <= '0;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
            if (!speed_100 && take && !crs_q) begin
                locked_q <= 1'b0;
            end
            smp_q.vld <= take;
            if (take) begin
                smp_q.d   <= rxd_q;
                smp_q.crs <= crs_q;
            end
        end
    end

    assign smp_o = smp_q;

    // R2: at the slow rate two samples are never adjacent.
    assert_single_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!speed_100 && smp_q.vld) |=> !smp_q.vld);

    // R1: at the fast rate a sample follows every cycle.
    assert_every_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        speed_100 |=> smp_q.vld);

endmodule

// File: rtl/rmii_rx_nibble.sv
// Nibble assembler: pairs decimated dibits, earlier dibit in the low half.
// A frame opens on the first non-zero dibit with carrier high and closes
// after END_LOW_RUN consecutive carrier-low samples. A partial nibble is
// dropped at close.
// Assumes: one sample per dibit period arrives through smp_i.
module rmii_rx_nibble
    import rmii_rx_pkg::*;
#(
    parameter int END_LOW_RUN = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  dibit_smp_t smp_i,
    output logic       nib_vld_o,
    output nibble_t    nib_o
);

    localparam int LW = $clog2(END_LOW_RUN + 1);
    localparam logic [LW-1:0] RUN_LAST = LW'(END_LOW_RUN - 1);

    logic          active_q;
    logic          half_q;
    dibit_t        lo_q;
    logic [LW-1:0] lowrun_q;
    nibble_t       nib_q;
    logic          nib_vld_q;
    logic          closing;

    // Frame closes on the last low sample of the required run.
    always_comb closing = smp_i.vld && active_q && !smp_i.crs && (lowrun_q == RUN_LAST);

    // Frame state, low-run count and nibble pairing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            half_q    <= 1'b0;
            lo_q      <= '0;
            lowrun_q  <= '0;
            nib_q     <= '0;
            nib_vld_q <= 1'b0;
        end else begin
            nib_vld_q <= 1'b0;
            if (smp_i.vld) begin
                if (!active_q) begin
                    lowrun_q <= '0;
                    half_q   <= 1'b0;
                    if (smp_i.crs && (smp_i.d != 2'b00)) begin
                        active_q <= 1'b1;
                        lo_q     <= smp_i.d;
                        half_q   <= 1'b1;
                    end
                end else if (closing) begin
                    active_q <= 1'b0;
                    half_q   <= 1'b0;
                    lowrun_q <= '0;
                end else begin
                    lowrun_q <= smp_i.crs ? '0 : lowrun_q + 1'b1;
                    if (half_q) begin
                        nib_q     <= {smp_i.d, lo_q};
                        nib_vld_q <= 1'b1;
                        half_q    <= 1'b0;
                    end else begin
                        lo_q   <= smp_i.d;
                        half_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign nib_vld_o = nib_vld_q;
    assign nib_o     = nib_q;

    // R4: no nibble can follow a cycle spent outside a frame.
    assert_idle_no_nibble_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |=> !nib_vld_q);

    // R5: a complete nibble needs two samples, so nibbles never come back to back.
    assert_pair_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        nib_vld_q |=> !nib_vld_q);

endmodule

// File: rtl/rmii_rx_mii_out.sv
// Output stage: divides the reference into the nibble-side receive clock.
// It holds one nibble in a hand-over register and moves it to the outputs
// on each rising edge of that clock.
// Assumes: nibbles arrive at the same average rate as clock rises.
module rmii_rx_mii_out
    import rmii_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 10
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    speed_100,
    input  logic    nib_vld_i,
    input  nibble_t nib_i,
    output logic    rx_clk_o,
    output nibble_t rxd_o,
    output logic    rx_dv_o
);

    localparam int CW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(OVERSAMPLE - 1);

    logic [CW-1:0] cnt_q;
    logic          clk_q;
    logic          clk_d;
    logic          rise;
    nibble_t       pend_q;
    logic          pend_full_q;
    nibble_t       rxd_q;
    logic          dv_q;

    // Next receive-clock level: toggle every cycle fast, every OVERSAMPLE slow.
    always_comb clk_d = (speed_100 || (cnt_q == CNT_LAST)) ? !clk_q : clk_q;

    // Rising edge of the rebuilt clock in this cycle.
    always_comb rise = clk_d && !clk_q;

    // Clock divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            clk_q <= 1'b0;
        end else begin
            clk_q <= clk_d;
            if (speed_100 || (cnt_q == CNT_LAST)) cnt_q <= '0;
            else                                  cnt_q <= cnt_q + 1'b1;
        end
    end

    // Hand-over register and output update on clock rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= '0;
            pend_full_q <= 1'b0;
            rxd_q       <= '0;
            dv_q        <= 1'b0;
        end else begin
            if (nib_vld_i) pend_q <= nib_i;
            if (rise) begin
                rxd_q       <= pend_full_q ? pend_q : '0;
                dv_q        <= pend_full_q;
                pend_full_q <= nib_vld_i;
            end else if (nib_vld_i) begin
                pend_full_q <= 1'b1;
            end
        end
    end

    assign rx_clk_o = clk_q;
    assign rxd_o    = rxd_q;
    assign rx_dv_o  = dv_q;

    // R7: outputs hold between rises of the rebuilt clock.
    assert_change_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(rx_clk_o) |-> ($stable(rxd_o) && $stable(rx_dv_o)));

    // R6: at the fast rate a high phase lasts one cycle.
    assert_fast_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_100 && rx_clk_o) |=> !rx_clk_o);

    // R8: reset clears the outputs.
    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (!rx_dv_o && !rx_clk_o && (rxd_o == 4'h0)));

endmodule

// File: rtl/rmii_rx_adapter.sv
// Top: reduced-pin receive (2 bits at 50 MHz) to nibble receive interface.
// Chain: decimator -> nibble assembler -> clocked output stage.
// Assumes: clk is the 50 MHz reference; speed_100 is static outside reset.
module rmii_rx_adapter
    import rmii_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 10,
    parameter int SAMPLE_IDX  = 4,
    parameter int END_LOW_RUN = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       speed_100,
    input  logic [1:0] rmii_rxd,
    input  logic       rmii_crs_dv,
    output logic       mii_rx_clk,
    output logic [3:0] mii_rxd,
    output logic       mii_rx_dv
);

    dibit_smp_t smp;
    logic       nib_vld;
    nibble_t    nib;

    rmii_rx_decim #(
        .OVERSAMPLE (OVERSAMPLE),
        .SAMPLE_IDX (SAMPLE_IDX)
    ) u_decim (
        .clk       (clk),
        .rst_n     (rst_n),
        .speed_100 (speed_100),
        .rxd_in    (rmii_rxd),
        .crs_in    (rmii_crs_dv),
        .smp_o     (smp)
    );

    rmii_rx_nibble #(
        .END_LOW_RUN (END_LOW_RUN)
    ) u_nibble (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_i     (smp),
        .nib_vld_o (nib_vld),
        .nib_o     (nib)
    );

    rmii_rx_mii_out #(
        .OVERSAMPLE (OVERSAMPLE)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .speed_100 (speed_100),
        .nib_vld_i (nib_vld),
        .nib_i     (nib),
        .rx_clk_o  (mii_rx_clk),
        .rxd_o     (mii_rxd),
        .rx_dv_o   (mii_rx_dv)
    );

endmodule

// File: tb/rmii_rx_adapter_tb.sv
module rmii_rx_adapter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       speed_100 = 1'b1;
    logic [1:0] rmii_rxd = 2'b00;
    logic       rmii_crs_dv = 1'b0;
    logic       mii_rx_clk;
    logic [3:0] mii_rxd;
    logic       mii_rx_dv;

    rmii_rx_adapter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .speed_100   (speed_100),
        .rmii_rxd    (rmii_rxd),
        .rmii_crs_dv (rmii_crs_dv),
        .mii_rx_clk  (mii_rx_clk),
        .mii_rxd     (mii_rxd),
        .mii_rx_dv   (mii_rx_dv)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit reported = 0;

    logic [3:0] expq [0:63];
    int         exp_n;
    logic [3:0] rec [0:127];
    int         rec_n = 0;
    int         stable_viol = 0;
    int         period_viol = 0;
    int         exp_period = 2;
    int         cyc = 0;
    int         last_rise = 0;
    bit         have_rise = 0;
    logic       p_clk = 0;
    logic [3:0] p_rxd = 0;
    logic       p_dv = 0;
    logic [7:0] lfsr = 8'hA7;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            have_rise = 0;
            p_clk = 0; p_rxd = 0; p_dv = 0;
        end else begin
            if (mii_rx_clk && !p_clk) begin
                if (have_rise && (cyc - last_rise != exp_period)) period_viol++;
                have_rise = 1;
                last_rise = cyc;
                if (mii_rx_dv) begin
                    if (rec_n < 128) rec[rec_n] = mii_rxd;
                    rec_n++;
                end
            end else if ((mii_rxd != p_rxd) || (mii_rx_dv != p_dv)) begin
                stable_viol++;
            end
            p_clk = mii_rx_clk; p_rxd = mii_rxd; p_dv = mii_rx_dv;
        end
        cyc++;
    end

    task automatic do_reset(input bit spd);
        @(negedge clk);
        rst_n = 1'b0;
        speed_100 = spd;
        rmii_rxd = 2'b00;
        rmii_crs_dv = 1'b0;
        exp_period = spd ? 2 : 20;
        repeat (3) @(negedge clk);
        // R8: outputs cleared while reset is held
        chk(mii_rx_dv == 1'b0, "R8", "dv in reset", int'(mii_rx_dv), 0);
        chk(mii_rxd == 4'h0, "R8", "rxd in reset", int'(mii_rxd), 0);
        chk(mii_rx_clk == 1'b0, "R8", "rx_clk in reset", int'(mii_rx_clk), 0);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
    endtask

    task automatic send_dibit(input logic [1:0] d, input logic c, input bit g);
        int hold;
        hold = speed_100 ? 1 : 10;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            rmii_rxd = (g && (i == 1 || i == 2 || i == 7 || i == 8)) ? ~d : d;
            rmii_crs_dv = c;
        end
    endtask

    function automatic logic [3:0] next_nib();
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        return lfsr[3:0];
    endfunction

    task automatic run_frame(input int nz, input int nnib, input int ntog, input bit glitch);
        logic [3:0] nb;
        bit tog;
        bit g;
        int mism;
        int first_bad;
        @(posedge clk);
        rec_n = 0; stable_viol = 0; period_viol = 0;
        exp_n = 0;
        for (int z = 0; z < nz; z++) send_dibit(2'b00, 1'b1, glitch);
        for (int k = 0; k < nnib; k++) begin
            nb = (k < 2) ? 4'h5 : next_nib();
            expq[exp_n] = nb;
            exp_n++;
            tog = (k >= nnib - ntog);
            g = glitch && !tog;
            send_dibit(nb[1:0], !tog, g);
            send_dibit(nb[3:2], 1'b1, g);
        end
        for (int z = 0; z < 8; z++) send_dibit(2'b00, 1'b0, 1'b0);
        // R4 R5 R9: nibble count equals nibbles sent after the leading zeros
        chk(rec_n == exp_n, "R4 R5 R9", "nibble count", rec_n, exp_n);
        mism = 0; first_bad = 0;
        for (int k = 0; k < exp_n && k < rec_n; k++) begin
            if (rec[k] !== expq[k]) begin
                if (mism == 0) first_bad = k;
                mism++;
            end
        end
        // R1 R2 R3: nibble contents and dibit order
        if (mism != 0)
            chk(1'b0, speed_100 ? "R1 R3" : "R2 R3", "nibble value",
                int'(rec[first_bad]), int'(expq[first_bad]));
        else
            chk(1'b1, "R1 R2 R3", "nibble value", 0, 0);
        // R7: outputs only moved on clock rises
        chk(stable_viol == 0, "R7", "changes off rise", stable_viol, 0);
        // R6: rise spacing
        chk(period_viol == 0, "R6", "clock period", period_viol, 0);
    endtask

    task automatic run_zero_burst();
        @(posedge clk);
        rec_n = 0;
        for (int z = 0; z < 9; z++) send_dibit(2'b00, 1'b1, 1'b0);
        for (int z = 0; z < 6; z++) send_dibit(2'b00, 1'b0, 1'b0);
        // R4: zero-only burst gives no valid nibble
        chk(rec_n == 0, "R4", "zero burst nibbles", rec_n, 0);
    endtask

    initial begin
        for (int s = 1; s >= 0; s--) begin
            do_reset(s[0]);
            for (int nz = 0; nz < 4; nz++) begin
                run_frame(nz, 8 + nz, nz % 3, (s == 0) && (nz % 2 == 1));
            end
            run_zero_burst();
            run_frame(1, (s == 1) ? 40 : 12, 2, s == 0);
        end
        report();
    end

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        report();
    end

endmodule